// File: doc/BRIEF.md
# Per-Hart Interrupt Claim Unit

This block delivers wired interrupts directly to a small set of harts (up to four by default). It watches an externally held pending vector and enable vector, keeps one routing register per source that names a destination hart, and drives one interrupt-request line per hart. Each hart also owns a 32-byte register window. The window's claim register, when read, hands back the lowest-numbered pending source routed to that hart. In the same cycle it issues a one-cycle strobe that tells the owner of the pending vector to clear that source.

Register access uses a simple request/response port controlled by a two-state engine. In `ST_IDLE` the port is ready. An accepted request (transition `ST_IDLE -> ST_RESP`) has its response (data and error flag) presented for exactly one cycle in `ST_RESP`. The engine then returns to `ST_IDLE` unconditionally (transition `ST_RESP -> ST_IDLE`). Source numbers run from 1 to `NSRC`, and source `s` is bit `s-1` of the pending, enable and clear vectors. Priority beyond the lowest index, thresholds and message delivery are not part of this block.

Top module: `ich_claim_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, every `irq` bit is 0, `clr_pend` is all zero, and every routing register reads back 0.
- R2: The routing register of source s (1..NSRC) is at byte offset 0x3004 + 4*(s-1). A write stores `req_wdata[31:18]` as the destination hart. A read returns that field in bits 31:18, and all lower bits read as 0.
- R3: `irq[h]` is 1 exactly when `dom_en` is 1 and some source is enabled, pending and routed to hart h.
- R4: A read at offset 0x4000 + 32*h + 0x1C returns `{6'b0, s[9:0], 8'b0, 8'b0}`. Here s is the lowest-numbered pending source routed to hart h, whatever its enable bit. The priority byte (bits 7:0) is always 0, and the word is 0 when no such source exists.
- R5: In the cycle a claim read is accepted, `clr_pend` has exactly bit s-1 set for the source being returned, or no bit if none. At every other time `clr_pend` is zero.
- R6: A write to a claim register raises no clear strobe and changes no pending or routing state.
- R7: Window offsets 0x00, 0x04, 0x08 and 0x18 of any hart respond without error, read as 0, and ignore writes.
- R8: Any other offset gives a response with `rsp_err` = 1 and data 0. This includes a misaligned or out-of-range routing offset, an unlisted window offset, and a window beyond `NHART`.
- R9: An accepted request is answered in the next cycle with `rsp_valid` high for one cycle, and `req_ready` is low in that cycle. A request presented while `req_ready` is low is ignored.
- R10: A source routed to a hart number of `NHART` or above raises no line and is never returned by any claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_en | input | 1 | Domain-wide delivery enable |
| pend_vec | input | NSRC | Pending flags, bit s-1 for source s |
| en_vec | input | NSRC | Enable flags, bit s-1 for source s |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped offset |
| clr_pend | output | NSRC | One-cycle request to clear a pending flag |
| irq | output | NHART | Per-hart interrupt request |

## Verification
Two events can fall in the same cycle: a claim read selecting and clearing a source, and a new pending flag arriving on a lower-numbered source for the same hart. The bench provokes this by injecting the new flag on the same edge that accepts the claim read. The response must name the source that was pending before that edge, with a matching one-hot clear strobe sampled in the request cycle. The newly injected source must then survive and be returned by the following claim.

// File: rtl/ich_pkg.sv
package ich_pkg;
    // Register map anchors (byte offsets)
    localparam int TGT_BASE  = 'h3004;
    localparam int WIN_BASE  = 'h4000;
    localparam int WIN_SHIFT = 5;

    // Field placement
    localparam int HART_LSB  = 18;
    localparam int HART_W    = 14;
    localparam int SRC_LSB   = 16;
    localparam int SRC_W     = 10;
    localparam int DATA_W    = 32;

    // Offsets inside a per-hart window
    localparam logic [4:0] WOFF_DELIV  = 5'h00;
    localparam logic [4:0] WOFF_FORCE  = 5'h04;
    localparam logic [4:0] WOFF_THRESH = 5'h08;
    localparam logic [4:0] WOFF_TOP    = 5'h18;
    localparam logic [4:0] WOFF_CLAIM  = 5'h1C;

    typedef enum logic [1:0] {
        ACC_BAD,
        ACC_TARGET,
        ACC_QUIET,
        ACC_CLAIM
    } acc_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } st_e;
endpackage

// File: rtl/ich_decode.sv
module ich_decode
    import ich_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int NHART  = 4,
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 6,
    parameter int HSEL_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind,
    output logic [SLOT_W-1:0] slot,
    output logic [HSEL_W-1:0] hsel
);
    localparam int TGT_LAST = TGT_BASE + (NSRC - 1) * 4;
    localparam int WIN_END  = WIN_BASE + NHART * (1 << WIN_SHIFT);

    logic in_tgt;
    logic in_win;

    always_comb begin
        in_tgt = (addr >= ADDR_W'(TGT_BASE)) && (addr <= ADDR_W'(TGT_LAST))
                 && (addr[1:0] == 2'b00);
        in_win = (addr >= ADDR_W'(WIN_BASE)) && (addr < ADDR_W'(WIN_END));
        slot   = SLOT_W'((addr - ADDR_W'(TGT_BASE)) >> 2);
        hsel   = HSEL_W'((addr - ADDR_W'(WIN_BASE)) >> WIN_SHIFT);
        kind   = ACC_BAD;
        if (in_tgt) begin
            kind = ACC_TARGET;
        end else if (in_win) begin
            // window base is 32-byte aligned, so the low five bits select the register
            case (addr[4:0])
                WOFF_CLAIM:                                   kind = ACC_CLAIM;
                WOFF_DELIV, WOFF_FORCE, WOFF_THRESH, WOFF_TOP: kind = ACC_QUIET;
                default:                                      kind = ACC_BAD;
            endcase
        end
    end
endmodule

// File: rtl/ich_target_bank.sv
module ich_target_bank
    import ich_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int SLOT_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SLOT_W-1:0]              wr_slot,
    input  logic [HART_W-1:0]              wr_hart,
    output logic [NSRC-1:0][HART_W-1:0]    hart_of
);
    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        logic [HART_W-1:0] dest_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dest_q <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                dest_q <= wr_hart;
            end
        end
        assign hart_of[s] = dest_q;
    end
endmodule

// File: rtl/ich_claim_pick.sv
module ich_claim_pick
    import ich_pkg::*;
#(
    parameter int NSRC = 63,
    parameter int HART = 0
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0]             en,
    input  logic [NSRC-1:0][HART_W-1:0] hart_of,
    input  logic                        dom_en,
    output logic                        req_line,
    output logic                        found,
    output logic [SRC_W-1:0]            src_num,
    output logic [NSRC-1:0]             sel_oh
);
    logic [NSRC-1:0] routed;
    logic [NSRC-1:0] cand;

    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            routed[k] = (hart_of[k] == HART_W'(HART));
        end
        cand     = routed & pend;
        req_line = dom_en && |(cand & en);
        found    = |cand;
        // isolate the lowest set bit: lowest source number wins
        sel_oh   = cand & (~cand + NSRC'(1));
        src_num  = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (cand[k]) begin
                src_num = SRC_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/ich_claim_unit.sv
module ich_claim_unit
    import ich_pkg::*;
#(
    parameter int NSRC   = 63,
    parameter int NHART  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dom_en,
    input  logic [NSRC-1:0]   pend_vec,
    input  logic [NSRC-1:0]   en_vec,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [NSRC-1:0]   clr_pend,
    output logic [NHART-1:0]  irq
);
    localparam int SLOT_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int HSEL_W = (NHART > 1) ? $clog2(NHART) : 1;

    st_e  state_q, state_d;
    acc_e kind;
    logic [SLOT_W-1:0] slot;
    logic [HSEL_W-1:0] hsel;
    logic [NSRC-1:0][HART_W-1:0] hart_of;
    logic [NHART-1:0] found_v;
    logic [SRC_W-1:0] src_v [NHART];
    logic [NSRC-1:0]  oh_v  [NHART];
    logic accept;
    logic claim_rd;
    logic tgt_wr;
    logic [DATA_W-1:0] rdata_d;
    logic err_d;
    logic wdata_unused;

    assign wdata_unused = ^req_wdata[HART_LSB-1:0];

    ich_decode #(
        .NSRC(NSRC), .NHART(NHART), .ADDR_W(ADDR_W),
        .SLOT_W(SLOT_W), .HSEL_W(HSEL_W)
    ) u_decode (
        .addr(req_addr), .kind(kind), .slot(slot), .hsel(hsel)
    );

    ich_target_bank #(.NSRC(NSRC), .SLOT_W(SLOT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(tgt_wr), .wr_slot(slot),
        .wr_hart(req_wdata[DATA_W-1:HART_LSB]), .hart_of(hart_of)
    );

    for (genvar h = 0; h < NHART; h++) begin : g_hart
        ich_claim_pick #(.NSRC(NSRC), .HART(h)) u_pick (
            .pend(pend_vec), .en(en_vec), .hart_of(hart_of), .dom_en(dom_en),
            .req_line(irq[h]), .found(found_v[h]), .src_num(src_v[h]),
            .sel_oh(oh_v[h])
        );
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign accept    = req_valid && req_ready;
    assign claim_rd  = accept && !req_write && (kind == ACC_CLAIM);
    assign tgt_wr    = accept && req_write && (kind == ACC_TARGET);
    assign clr_pend  = (claim_rd && found_v[hsel]) ? oh_v[hsel] : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // response word for the request in flight
    always_comb begin
        rdata_d = '0;
        err_d   = 1'b0;
        case (kind)
            ACC_TARGET: if (!req_write) rdata_d = {hart_of[slot], {HART_LSB{1'b0}}};
            ACC_CLAIM:  if (!req_write && found_v[hsel])
                            rdata_d = DATA_W'(src_v[hsel]) << SRC_LSB;
            ACC_QUIET:  rdata_d = '0;
            default:    err_d = 1'b1;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_rdata <= rdata_d;
            rsp_err   <= err_d;
        end else begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end
    end
endmodule

// File: rtl/ich_claim_unit_chk.sv
module ich_claim_unit_chk #(
    parameter int NSRC   = 63,
    parameter int NHART  = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dom_en,
    input logic [NSRC-1:0]   pend_vec,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [NSRC-1:0]   clr_pend,
    input logic [NHART-1:0]  irq
);
    logic addr_unused;
    assign addr_unused = ^req_addr;

    // R9
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R9
    resp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R5
    clear_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_pend));
    // R6
    clear_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend != '0) |-> (req_valid && req_ready && !req_write));
    // R5
    clear_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend & ~pend_vec) == '0);
    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    // R3
    irq_domain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_en |-> (irq == '0));
endmodule

bind ich_claim_unit ich_claim_unit_chk #(
    .NSRC(NSRC), .NHART(NHART), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .pend_vec(pend_vec),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .clr_pend(clr_pend), .irq(irq)
);

// File: tb/ich_claim_unit_test.sv
module ich_claim_unit_test;
    localparam int NSRC  = 63;
    localparam int NHART = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             dom_en = 1'b0;
    logic [NSRC-1:0]  pend_vec;
    logic [NSRC-1:0]  en_vec = '0;
    logic [NSRC-1:0]  inj = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [15:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;
    logic             rsp_err;
    logic [NSRC-1:0]  clr_pend;
    logic [NHART-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [13:0] tgt_m [NSRC];

    ich_claim_unit #(.NSRC(NSRC), .NHART(NHART), .ADDR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .pend_vec(pend_vec),
        .en_vec(en_vec), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .clr_pend(clr_pend), .irq(irq)
    );

    // environment-owned pending flags: set by injection, cleared by the strobe
    always @(posedge clk) begin
        if (!rst_n) pend_vec <= '0;
        else        pend_vec <= (pend_vec & ~clr_pend) | inj;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NSRC-1:0] exp_oh(input int h);
        for (int k = 0; k < NSRC; k++)
            if (pend_vec[k] && tgt_m[k] == 14'(h)) return NSRC'(1) << k;
        return '0;
    endfunction

    function automatic logic [31:0] exp_claim(input int h);
        for (int k = 0; k < NSRC; k++)
            if (pend_vec[k] && tgt_m[k] == 14'(h)) return 32'(k + 1) << 16;
        return 32'h0;
    endfunction

    function automatic logic [NHART-1:0] exp_irq();
        logic [NHART-1:0] r = '0;
        for (int h = 0; h < NHART; h++)
            for (int k = 0; k < NSRC; k++)
                if (dom_en && pend_vec[k] && en_vec[k] && tgt_m[k] == 14'(h)) r[h] = 1'b1;
        return r;
    endfunction

    // caller is at a negedge; ends at the negedge of the response cycle
    task automatic xfer(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [NSRC-1:0] im, output logic [31:0] rd,
                        output bit er, output logic [NSRC-1:0] cs);
        chk("R9 ready in idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; inj = im;
        #1 cs = clr_pend;
        @(negedge clk);
        chk("R9 response valid", rsp_valid, 1);
        chk("R9 not ready while responding", req_ready, 0);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 1'b0; inj = '0;
    endtask

    task automatic tgt_write(input int s, input logic [13:0] hv, input logic [17:0] junk);
        logic [31:0] rd; bit er; logic [NSRC-1:0] cs;
        @(negedge clk);
        xfer(1, 16'(16'h3004 + (s - 1) * 4), {hv, junk}, '0, rd, er, cs);
        chk("R2 write no error", er, 0);
        chk("R2 write no clear", cs, 0);
        tgt_m[s-1] = hv;
    endtask

    task automatic tgt_read(input int s);
        logic [31:0] rd; bit er; logic [NSRC-1:0] cs;
        @(negedge clk);
        xfer(0, 16'(16'h3004 + (s - 1) * 4), 0, '0, rd, er, cs);
        chk("R2 routing readback", rd, {tgt_m[s-1], 18'h0});
        chk("R2 read no error", er, 0);
    endtask

    task automatic claim(input int h, input logic [NSRC-1:0] im);
        logic [31:0] rd, e; bit er; logic [NSRC-1:0] cs, eo;
        @(negedge clk);
        e = exp_claim(h); eo = exp_oh(h);
        xfer(0, 16'(16'h401C + h * 32), 0, im, rd, er, cs);
        chk("R4 claim word", rd, e);
        chk("R5 clear strobe", cs, eo);
        chk("R4 claim no error", er, 0);
    endtask

    task automatic inject(input logic [NSRC-1:0] m);
        @(negedge clk); inj = m;
        @(negedge clk); inj = '0;
    endtask

    task automatic irq_check();
        @(negedge clk);
        chk("R3 request lines", irq, exp_irq());
    endtask

    task automatic plain(input bit wr, input logic [15:0] a, input bit exp_err, input string tag);
        logic [31:0] rd; bit er; logic [NSRC-1:0] cs;
        @(negedge clk);
        xfer(wr, a, $urandom, '0, rd, er, cs);
        chk({tag, " data"}, rd, 0);
        chk({tag, " err"}, er, exp_err);
        chk({tag, " no clear"}, cs, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd; bit er; logic [NSRC-1:0] cs;
        logic [15:0] bad [8];
        void'($urandom(32'd20240611));
        for (int k = 0; k < NSRC; k++) tgt_m[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 clear idle", clr_pend, 0);
        tgt_read(5);
        tgt_read(63);

        // R2 routing with junk in low bits
        tgt_write(3, 14'd2, 18'h3FFFF);
        tgt_write(7, 14'd2, 18'h0);
        tgt_write(10, 14'd1, 18'h15A5A);
        tgt_write(63, 14'd3, 18'h0);
        tgt_write(20, 14'd9, 18'h0);   // R10 out-of-range hart
        tgt_read(3); tgt_read(10); tgt_read(63); tgt_read(20);

        // R3 request lines
        @(negedge clk); dom_en = 1'b1; en_vec = '1;
        inject((NSRC'(1) << 2) | (NSRC'(1) << 6) | (NSRC'(1) << 9) |
               (NSRC'(1) << 62) | (NSRC'(1) << 19));
        irq_check();
        chk("R10 hart 0 quiet", irq[0], 0);
        @(negedge clk); dom_en = 1'b0;
        irq_check();
        @(negedge clk); dom_en = 1'b1;
        irq_check();

        // R4 and R5 lowest-index selection and clear
        claim(2, '0); claim(2, '0); claim(2, '0);
        irq_check();

        // R6 claim write leaves state alone
        @(negedge clk);
        xfer(1, 16'h403C, 32'hFFFF_FFFF, '0, rd, er, cs);
        chk("R6 claim write no clear", cs, 0);
        chk("R6 claim write no error", er, 0);
        claim(1, '0);

        // R4 enable does not gate a claim
        @(negedge clk); en_vec[62] = 1'b0;
        irq_check();
        claim(3, '0);

        // R10 source routed to hart 9 never claimed
        for (int h = 0; h < NHART; h++) claim(h, '0);
        chk("R10 still pending", pend_vec[19], 1);

        // same-cycle arrival of a lower source during a claim
        tgt_write(4, 14'd0, 18'h0);
        tgt_write(5, 14'd0, 18'h0);
        inject(NSRC'(1) << 4);
        claim(0, NSRC'(1) << 3);
        chk("R5 fresh source kept", pend_vec[3], 1);
        claim(0, '0);

        // R7 quiet window registers
        for (int h = 0; h < NHART; h++) begin
            plain(0, 16'(16'h4000 + h * 32), 0, "R7 deliv read");
            plain(1, 16'(16'h4004 + h * 32), 0, "R7 force write");
            plain(0, 16'(16'h4008 + h * 32), 0, "R7 threshold read");
            plain(0, 16'(16'h4018 + h * 32), 0, "R7 top read");
        end
        plain(1, 16'h4000, 0, "R7 deliv write");
        plain(0, 16'h4000, 0, "R7 deliv after write");

        // R8 unmapped offsets
        bad[0] = 16'h0000; bad[1] = 16'h3000; bad[2] = 16'h3006; bad[3] = 16'h3100;
        bad[4] = 16'h4010; bad[5] = 16'h4080; bad[6] = 16'h2000; bad[7] = 16'h401D;
        for (int i = 0; i < 8; i++) plain(i % 2 == 1, bad[i], 1, "R8 unmapped");

        // R9 request presented while busy is dropped
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h3004; req_wdata = {14'd2, 18'h0};
        @(negedge clk);
        req_addr = 16'h3008; req_wdata = {14'd3, 18'h0};
        @(negedge clk);
        req_valid = 1'b0;
        tgt_m[0] = 14'd2;
        tgt_read(1);
        tgt_read(2);

        // constrained random mix
        for (int it = 0; it < 1500; it++) begin
            int op = $urandom % 6;
            case (op)
                0: tgt_write(1 + $urandom % NSRC, 14'($urandom % 6), 18'($urandom));
                1: begin
                    logic [NSRC-1:0] m = '0;
                    for (int k = 0; k < NSRC; k++) m[k] = ($urandom % 10 == 0);
                    inject(m);
                end
                2: begin
                    logic [NSRC-1:0] m = '0;
                    if ($urandom % 3 == 0) m[$urandom % NSRC] = 1'b1;
                    claim($urandom % NHART, m);
                end
                3: tgt_read(1 + $urandom % NSRC);
                4: begin
                    @(negedge clk);
                    dom_en = ($urandom % 4 != 0);
                    for (int k = 0; k < NSRC; k++) en_vec[k] = ($urandom % 3 != 0);
                    irq_check();
                end
                default: begin
                    if ($urandom % 2 == 0)
                        plain($urandom % 2, 16'(16'h4008 + ($urandom % NHART) * 32), 0, "R7 random quiet");
                    else
                        plain($urandom % 2, 16'(16'h4080 + ($urandom % 64) * 4), 1, "R8 random unmapped");
                end
            endcase
        end
        irq_check();

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule